// File: doc/BRIEF.md
# Buffered-Duty Timer PWM Generator

This block produces one pulse-width modulated output from a free-running period timer. An 8-bit timer counts up to a programmed period value. Below it, a 2-bit fine count is driven from a prescaler, and the two together form a 10-bit time base. The output rises when a period starts and falls when the 10-bit time base reaches the duty value. The whole period lasts (period + 1) × 4 × prescale input clocks.

Software reaches the block through a small write port. The 10-bit duty value is split between an 8-bit register and a 2-bit field of the control register. That value is not used directly. It goes into a shadow register, which loads only when the timer wraps at the end of a period. A write made mid-period therefore never cuts a pulse short or stretches it. Clearing the run bit stops the timer at zero and drives the output low.

Top module: `shadow_pwm`

## Requirements
- R1: After reset the output is low, the timer is stopped, and every register, the shadow duty included, holds zero.
- R2: A write with `wr_addr` 0 sets the period, 1 sets the duty high byte, and 2 sets control. In control, bits [1:0] are the duty low bits, bit 2 is run, and bits [4:3] select the prescale. The duty is {high byte, low bits}.
- R3: While running, each period lasts (period + 1) × 4 × prescale clocks. The output rises only at the start of a period, in the cycle right after the run bit is written high or right after a wrap.
- R4: Within a period the output stays high for duty × prescale clocks and is low for the rest.
- R5: A duty write takes effect only from the period after the next wrap. The first period after the run bit is set uses the shadow value held from before.
- R6: A shadow duty of zero keeps the output low for the whole period.
- R7: A shadow duty of at least 4 × (period + 1) keeps the output high for the whole period.
- R8: Writing control with run = 0 drives the output low in the next cycle and holds the timer at zero. The shadow duty is kept. Setting run again starts a fresh period from timer value zero.
- R9: Prescale select 0 gives a ratio of 1, 1 gives 4, and 2 or 3 gives 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 8 | Write data |
| pwm_out | output | 1 | PWM output |

## Verification
The bench measures whole periods and compares the high time and the pulse shape against values predicted from the requirements.

It goes after the following corner cases, each paired with the fault it would expose:

- **First period after enabling.** It must show the stale shadow value. A design that loads the duty on enable would show the new duty one period early.
- **Mid-period duty write.** A design without the buffer would change the pulse inside the current period.
- **Zero duty.** A design that sets the output unconditionally at the period start would emit a one-step glitch.
- **Oversized duty.** A design that compares with wrap-around would produce a short pulse instead of a solid high level.
- **Period of zero, and prescales of 4 and 16.** These catch off-by-one errors in the timer wrap and in the fine-count extraction.
- **Clearing the run bit while the output is high.** The output must drop at once, and the next enable must restart the period from zero.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
    parameter int TMR_W        = 8;
    parameter int FINE_W       = 2;
    parameter int DATA_W       = 8;
    parameter int ADDR_W       = 2;
    parameter int PS_SEL_W     = 2;
    parameter int PS_SHIFT_MAX = 4;

    localparam int DUTY_W = TMR_W + FINE_W;
    localparam int PC_W   = FINE_W + PS_SHIFT_MAX;

    localparam int CTL_LO  = 0;
    localparam int CTL_RUN = FINE_W;
    localparam int CTL_PS  = FINE_W + 1;

    typedef enum logic [ADDR_W-1:0] {
        A_PERIOD  = 2'd0,
        A_DUTY_HI = 2'd1,
        A_CTRL    = 2'd2
    } reg_addr_e;

    typedef struct packed {
        logic [TMR_W-1:0]    period;
        logic [TMR_W-1:0]    duty_hi;
        logic [FINE_W-1:0]   duty_lo;
        logic                run;
        logic [PS_SEL_W-1:0] ps_sel;
    } cfg_t;

    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic [TMR_W-1:0] tmr;
    } tb_state_t;

    typedef struct packed {
        logic [DUTY_W-1:0] shadow;
        logic              out;
    } sh_state_t;

    function automatic int shift_of(logic [PS_SEL_W-1:0] sel);
        int s;
        s = 2 * int'(sel);
        if (s > PS_SHIFT_MAX) s = PS_SHIFT_MAX;
        return s;
    endfunction

    function automatic logic [FINE_W-1:0] fine_of(logic [PC_W-1:0] pc, logic [PS_SEL_W-1:0] sel);
        logic [PC_W-1:0] shifted;
        shifted = pc >> shift_of(sel);
        return shifted[FINE_W-1:0];
    endfunction

    function automatic logic [PC_W-1:0] last_of(logic [PS_SEL_W-1:0] sel);
        logic [PC_W:0] span;
        span = (PC_W+1)'(1) << (FINE_W + shift_of(sel));
        return PC_W'(span - 1'b1);
    endfunction
endpackage

// File: rtl/spwm_regs.sv
module spwm_regs
    import spwm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [TMR_W-1:0]    period_q,
    output logic [DUTY_W-1:0]   duty_q,
    output logic                run_q,
    output logic [PS_SEL_W-1:0] ps_sel_q,
    output logic                run_nx,
    output logic [PS_SEL_W-1:0] ps_sel_nx
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (wr_addr)
                A_PERIOD:  cfg_d.period  = wr_data[TMR_W-1:0];
                A_DUTY_HI: cfg_d.duty_hi = wr_data[TMR_W-1:0];
                A_CTRL: begin
                    cfg_d.duty_lo = wr_data[CTL_LO +: FINE_W];
                    cfg_d.run     = wr_data[CTL_RUN];
                    cfg_d.ps_sel  = wr_data[CTL_PS +: PS_SEL_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign period_q  = cfg_q.period;
    assign duty_q    = {cfg_q.duty_hi, cfg_q.duty_lo};
    assign run_q     = cfg_q.run;
    assign ps_sel_q  = cfg_q.ps_sel;
    assign run_nx    = cfg_d.run;
    assign ps_sel_nx = cfg_d.ps_sel;
endmodule

// File: rtl/spwm_timebase.sv
module spwm_timebase
    import spwm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TMR_W-1:0]    period,
    input  logic [PS_SEL_W-1:0] ps_sel,
    input  logic [PS_SEL_W-1:0] ps_sel_nx,
    input  logic                run_q,
    input  logic                run_nx,
    output logic [TMR_W-1:0]    tmr,
    output logic [DUTY_W-1:0]   base,
    output logic [DUTY_W-1:0]   base_nx,
    output logic                wrap
);
    tb_state_t s_d, s_q;
    logic      tick;

    always_comb begin
        s_d  = s_q;
        tick = (s_q.pc >= last_of(ps_sel));
        wrap = run_q && run_nx && tick && (s_q.tmr == period);
        if (!run_nx) begin
            s_d = '0;
        end else if (run_q) begin
            if (tick) begin
                s_d.pc  = '0;
                s_d.tmr = (s_q.tmr == period) ? '0 : s_q.tmr + 1'b1;
            end else begin
                s_d.pc = s_q.pc + 1'b1;
            end
        end
        base_nx = {s_d.tmr, fine_of(s_d.pc, ps_sel_nx)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tmr  = s_q.tmr;
    assign base = {s_q.tmr, fine_of(s_q.pc, ps_sel)};
endmodule

// File: rtl/spwm_shadow.sv
module spwm_shadow
    import spwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] duty,
    input  logic              wrap,
    input  logic              run_nx,
    input  logic [DUTY_W-1:0] base_nx,
    output logic [DUTY_W-1:0] shadow,
    output logic              out
);
    sh_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.shadow = wrap ? duty : st_q.shadow;
        st_d.out    = run_nx && (base_nx < st_d.shadow);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shadow = st_q.shadow;
    assign out    = st_q.out;
endmodule

// File: rtl/shadow_pwm.sv
module shadow_pwm
    import spwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pwm_out
);
    logic [TMR_W-1:0]    period_w;
    logic [DUTY_W-1:0]   duty_w;
    logic                run_w;
    logic                run_nx_w;
    logic [PS_SEL_W-1:0] ps_sel_w;
    logic [PS_SEL_W-1:0] ps_sel_nx_w;
    logic [TMR_W-1:0]    tmr_w;
    logic [DUTY_W-1:0]   base_w;
    logic [DUTY_W-1:0]   base_nx_w;
    logic                wrap_w;
    logic [DUTY_W-1:0]   shadow_w;

    spwm_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .period_q  (period_w),
        .duty_q    (duty_w),
        .run_q     (run_w),
        .ps_sel_q  (ps_sel_w),
        .run_nx    (run_nx_w),
        .ps_sel_nx (ps_sel_nx_w)
    );

    spwm_timebase u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .period    (period_w),
        .ps_sel    (ps_sel_w),
        .ps_sel_nx (ps_sel_nx_w),
        .run_q     (run_w),
        .run_nx    (run_nx_w),
        .tmr       (tmr_w),
        .base      (base_w),
        .base_nx   (base_nx_w),
        .wrap      (wrap_w)
    );

    spwm_shadow u_sh (
        .clk     (clk),
        .rst_n   (rst_n),
        .duty    (duty_w),
        .wrap    (wrap_w),
        .run_nx  (run_nx_w),
        .base_nx (base_nx_w),
        .shadow  (shadow_w),
        .out     (pwm_out)
    );
endmodule

// File: rtl/spwm_chk.sv
module spwm_chk
    import spwm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              pwm_out,
    input logic              run,
    input logic [TMR_W-1:0]  period,
    input logic [TMR_W-1:0]  tmr,
    input logic [DUTY_W-1:0] base,
    input logic [DUTY_W-1:0] shadow,
    input logic              wrap
);
    // R8
    run_off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !pwm_out);

    // R8
    timer_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (tmr == '0));

    // R3
    wrap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (tmr == '0));

    // R3
    rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out) |-> (base == '0));

    // R4
    fall_at_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pwm_out) && run) |-> (base == shadow));

    // R5
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(shadow));

    // R6
    zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shadow == '0) |-> !pwm_out);

    // R7
    full_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (tmr <= period) && (shadow > {period, {FINE_W{1'b1}}})) |-> pwm_out);
endmodule

bind shadow_pwm spwm_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwm_out (pwm_out),
    .run     (run_w),
    .period  (period_w),
    .tmr     (tmr_w),
    .base    (base_w),
    .shadow  (shadow_w),
    .wrap    (wrap_w)
);

// File: tb/sim_shadow_pwm.sv
module sim_shadow_pwm;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       pwm_out;

    int checks = 0;
    int errors = 0;
    int prev_duty = 0;
    bit done = 1'b0;
    bit busy = 1'b0;

    int    exp_hi[$];
    int    exp_len[$];
    string exp_req[$];

    int    m_hi, m_len, m_cnt;
    string m_req;
    bit    m_shape, m_low;

    always #2 clk = ~clk;

    shadow_pwm u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm_out (pwm_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // returns after the capturing edge; the cycle that follows is the first affected one
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    function automatic int ratio(input int sel);
        return (sel == 0) ? 1 : (sel == 1) ? 4 : 16;
    endfunction

    function automatic int high_of(input int d, input int pr, input int sel);
        int span;
        span = 4 * (pr + 1);
        return ((d > span) ? span : d) * ratio(sel);
    endfunction

    task automatic push(input int hi, input int len, input string req);
        exp_hi.push_back(hi);
        exp_len.push_back(len);
        exp_req.push_back(req);
    endtask

    task automatic drain();
        while (exp_len.size() > 0 || busy) @(negedge clk);
    endtask

    // R2 register map: addr 0 period, 1 duty high, 2 control {ps[4:3], run[2], lo[1:0]}
    task automatic setup_run(input int pr, input int dhi, input int dlo, input int sel);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'(pr));
        wr(2'd1, 8'(dhi));
        wr(2'd2, 8'((sel << 3) | 4 | dlo));
    endtask

    task automatic run_case(input int pr, input int dhi, input int dlo, input int sel,
                            input int nper, input string first_req, input string req);
        int d;
        int len;
        d   = dhi * 4 + dlo;
        len = 4 * (pr + 1) * ratio(sel);
        setup_run(pr, dhi, dlo, sel);
        push(high_of(prev_duty, pr, sel), len, first_req);
        for (int i = 1; i < nper; i++) push(high_of(d, pr, sel), len, req);
        prev_duty = d;
        drain();
    endtask

    // monitor: pops one expected period, measures it from cycle 0
    initial begin
        forever begin
            @(negedge clk);
            if (exp_len.size() > 0) begin
                busy    = 1'b1;
                m_hi    = exp_hi.pop_front();
                m_len   = exp_len.pop_front();
                m_req   = exp_req.pop_front();
                m_cnt   = 0;
                m_shape = 1'b1;
                m_low   = 1'b0;
                for (int i = 0; i < m_len; i++) begin
                    if (i > 0) @(negedge clk);
                    if (pwm_out) begin
                        m_cnt++;
                        if (m_low) m_shape = 1'b0;
                    end else begin
                        m_low = 1'b1;
                    end
                end
                chk(m_req, m_shape ? m_cnt : -1, m_hi);
                busy = 1'b0;
            end
        end
    end

    initial begin
        int lows;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 out in reset", int'(pwm_out), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 out after reset", int'(pwm_out), 0);

        // R8 timer stays stopped without run
        wr(2'd0, 8'd3);
        wr(2'd1, 8'd1);
        lows = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!pwm_out) lows++;
        end
        chk("R8 idle low", lows, 20);

        // R1 first period shows zeroed shadow; R3 R4 prescale 1
        run_case(3, 1, 2, 0, 3, "R1 shadow zero", "R4 R3 duty6");
        // R9 ratio 4, R2 low bits used
        run_case(2, 1, 1, 1, 3, "R5 stale shadow", "R9 R2 R4 ratio4");
        // R9 ratio 16
        run_case(1, 0, 2, 2, 2, "R5 stale ratio16", "R9 R3 ratio16");
        // R6 zero duty
        run_case(4, 0, 0, 0, 3, "R5 stale before zero", "R6 zero duty");
        // R7 oversized duty
        run_case(2, 10, 0, 0, 3, "R6 zero carried", "R7 full duty");
        // R3 period register zero
        run_case(0, 0, 3, 0, 3, "R7 carried full", "R3 period0");

        // R5 mid-period duty write waits for the next wrap
        setup_run(3, 2, 0, 0);
        push(high_of(prev_duty, 3, 0), 16, "R5 first");
        push(8, 16, "R4 before change");
        push(8, 16, "R5 holds old duty");
        push(12, 16, "R5 new duty");
        push(12, 16, "R5 new duty again");
        repeat (36) @(negedge clk);
        wr(2'd1, 8'd3);
        prev_duty = 12;
        drain();

        // R8 clearing run while high
        run_case(1, 20, 0, 0, 2, "R7 oversized first", "R7 oversized");
        @(negedge clk);
        chk("R7 high before clear", int'(pwm_out), 1);
        wr(2'd2, 8'h00);
        @(negedge clk);
        chk("R8 low after clear", int'(pwm_out), 0);
        lows = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!pwm_out) lows++;
        end
        chk("R8 stays low", lows, 30);
        wr(2'd2, 8'h04);
        push(8, 8, "R8 restart keeps shadow");
        push(8, 8, "R8 second period");
        drain();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule